// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

A memory-mapped peripheral that keeps a 32-bit count of seconds and raises a level interrupt when that count reaches a programmed match value. A prescaler divides the system clock into a one-cycle tick once per second, and each tick advances the count. The count wraps freely at 2^32. Software reaches the block through a simple APB-style slave port in a 4 KB window. Through that port it can load a new count, set the match value, gate the interrupt with a one-bit mask, and acknowledge the alarm.

The alarm is an event and not a level compare. The comparison runs only when the count or the match value changes, which happens on a tick, a load write or a match write. It fires when the new count equals the new match value. A two-state machine holds the raw status. State `AL_QUIET` takes the *raise* transition to `AL_RAISED` on a compare hit. `AL_RAISED` takes the *acknowledge* transition back to `AL_QUIET` on a clear-register write with no hit in the same cycle. Otherwise it *holds*. The interrupt pin is the raw status gated by the mask.

Register offsets, all word-aligned: 0x00 count, 0x04 match, 0x08 load, 0x0C control, 0x10 mask, 0x14 raw status, 0x18 masked status, 0x1C clear. The identification bytes sit at 0xFE0 to 0xFFC.

Top module: `rtc_alarm_apb`

## Requirements
- R1: After reset, count, match, load, mask and raw status all read 0 and `irq_o` is 0.
- R2: The count at 0x00 advances by one every `TICKS_PER_SEC` clock cycles and wraps from 0xFFFFFFFF to 0.
- R3: A write to 0x08 sets the count to the written value at that clock edge. Reading 0x08 returns the last value written there. If a write to 0x08 and a tick fall in the same cycle, the count takes the written value and the tick is lost.
- R4: When a tick makes the count equal to the value at 0x04, raw status (bit 0 of 0x14) becomes 1 in the next cycle. This includes a match value below the count, which is reached after the count wraps.
- R5: A write to 0x04 or 0x08 that leaves the count equal to the match value sets raw status in the next cycle.
- R6: A write to 0x10 stores only data bit 0 as the mask. `irq_o` equals raw status AND mask, and 0x18 reads that same bit.
- R7: Any write to 0x1C, whatever the data, clears raw status. If a compare hit occurs in the same cycle, raw status stays 1.
- R8: 0x0C always reads 1, and writes to it have no effect.
- R9: Writes to 0x00, 0x14 and 0x18 change nothing. Reads of 0x1C, of unmapped offsets and of offsets that are not word-aligned return 0.
- R10: Word-aligned reads of 0xFE0 to 0xFFC return, in increasing address order, 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits 7:0.
- R11: A write takes effect at the clock edge where `psel`, `penable` and `pwrite` are all high. `prdata` is valid combinationally while `psel` is high and `pwrite` is low, and is 0 otherwise. There are no wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | 12 | Byte offset in the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| irq_o | output | 1 | Level interrupt, raw status AND mask |

## Verification
The assertions check four things on every cycle. A tick without a load advances the count by exactly one. A load lands on the following cycle. Any compare hit leaves the machine in `AL_RAISED`, and an acknowledge without a hit leaves it in `AL_QUIET`. The mask keeps only bit 0.

Some behaviour shows only in the bench scenarios. These are wrap-around firing, the exact cycle alignment of a load or a clear against a tick, the constant control register, reads that must return 0, and the identification bytes. The bench compares the interrupt pin against its own model on every clock, and compares every read against that model.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_COUNT  = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_MATCH  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_LOAD   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_MSTAT  = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h01C;
    localparam logic [6:0]        ID_PAGE    = 7'h7F;   // paddr[11:5] of 0xFE0..0xFFF

    typedef enum logic {AL_QUIET, AL_RAISED} alarm_state_e;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        unique case (idx)
            3'd0: b = 8'h31;
            3'd1: b = 8'h10;
            3'd2: b = 8'h14;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            3'd7: b = 8'hB1;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
    parameter int DIV = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] pre_q;

    assign tick_o = (pre_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pre_q <= '0;
        else if (tick_o) pre_q <= '0;
        else             pre_q <= pre_q + 1'b1;
    end

    generate
        if (DIV > 1) begin : g_pulse_chk
            // R2: a tick lasts one cycle when the divider is above one
            assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] count_o,
    output logic [W-1:0] count_nxt_o
);
    logic [W-1:0] cnt_q;

    always_comb begin
        if (load_i)      count_nxt_o = load_val_i;
        else if (tick_i) count_nxt_o = cnt_q + 1'b1;
        else             count_nxt_o = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= count_nxt_o;
    end

    assign count_o = cnt_q;

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i) |=> (count_o == $past(count_o) + 1'b1));

    assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_o == $past(load_val_i)));
endmodule

// File: rtl/rtc_alarm_fsm.sv
module rtc_alarm_fsm
    import rtc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         eval_i,
    input  logic [W-1:0] count_nxt_i,
    input  logic [W-1:0] match_nxt_i,
    input  logic         clear_i,
    output logic         raised_o
);
    alarm_state_e state_q, state_d;
    logic hit;

    assign hit = eval_i && (count_nxt_i == match_nxt_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AL_QUIET:  if (hit) state_d = AL_RAISED;                 // raise
            AL_RAISED: if (clear_i && !hit) state_d = AL_QUIET;      // acknowledge
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= AL_QUIET;
        else        state_q <= state_d;
    end

    always_comb raised_o = (state_q == AL_RAISED);

    // R4 and R5: any compare hit leaves the alarm raised
    assert_hit_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> raised_o);

    assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !hit) |=> !raised_o);
endmodule

// File: rtl/rtc_alarm_apb.sv
module rtc_alarm_apb
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 100_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              irq_o
);
    logic              wr_en, wr_match, wr_load, wr_mask, wr_clear;
    logic              tick, raised;
    logic [DATA_W-1:0] match_q, load_q, match_nxt, count, count_nxt;
    logic              mask_q;
    logic [DATA_W-1:0] rd_data;

    assign wr_en    = psel && penable && pwrite;
    assign wr_match = wr_en && (paddr == OFS_MATCH);
    assign wr_load  = wr_en && (paddr == OFS_LOAD);
    assign wr_mask  = wr_en && (paddr == OFS_MASK);
    assign wr_clear = wr_en && (paddr == OFS_CLEAR);

    rtc_tick_gen #(.DIV(TICKS_PER_SEC)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    rtc_sec_counter #(.W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(wr_load),
        .load_val_i(pwdata), .count_o(count), .count_nxt_o(count_nxt)
    );

    assign match_nxt = wr_match ? pwdata : match_q;

    rtc_alarm_fsm #(.W(DATA_W)) u_alarm (
        .clk(clk), .rst_n(rst_n),
        .eval_i(tick || wr_load || wr_match),
        .count_nxt_i(count_nxt), .match_nxt_i(match_nxt),
        .clear_i(wr_clear), .raised_o(raised)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= '0;
            load_q  <= '0;
            mask_q  <= 1'b0;
        end else begin
            if (wr_match) match_q <= pwdata;
            if (wr_load)  load_q  <= pwdata;
            if (wr_mask)  mask_q  <= pwdata[0];
        end
    end

    always_comb begin
        rd_data = '0;
        if (paddr[ADDR_W-1:5] == ID_PAGE && paddr[1:0] == 2'b00) begin
            rd_data = {{(DATA_W-8){1'b0}}, id_byte(paddr[4:2])};
        end else begin
            unique case (paddr)
                OFS_COUNT: rd_data = count;
                OFS_MATCH: rd_data = match_q;
                OFS_LOAD:  rd_data = load_q;
                OFS_CTRL:  rd_data = 32'd1;
                OFS_MASK:  rd_data = {31'd0, mask_q};
                OFS_RAW:   rd_data = {31'd0, raised};
                OFS_MSTAT: rd_data = {31'd0, raised & mask_q};
                default:   rd_data = '0;
            endcase
        end
    end

    assign prdata = (psel && !pwrite) ? rd_data : '0;
    assign irq_o  = raised & mask_q;

    assert_mask_bit0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (mask_q == $past(pwdata[0])));

    assert_match_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_match |=> (match_q == $past(pwdata)));
endmodule

// File: tb/sim_rtc_alarm_apb.sv
module sim_rtc_alarm_apb;
    localparam int DIV = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq_o;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;  // 125 MHz

    rtc_alarm_apb #(.TICKS_PER_SEC(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_o(irq_o)
    );

    // behavioural reference
    bit [31:0] m_cnt, m_mr, m_lr;
    bit        m_mask, m_raw;
    int        pcnt;
    bit [7:0]  ids [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_mr = 0; m_lr = 0; m_mask = 0; m_raw = 0; pcnt = 0;
        end else begin
            bit wr, tk, evt;
            bit [31:0] nc, nm;
            wr = psel && penable && pwrite;
            tk = (pcnt == DIV - 1);
            pcnt = tk ? 0 : pcnt + 1;
            nc = m_cnt; nm = m_mr; evt = 0;
            if (wr && paddr == 12'h008) begin nc = pwdata; m_lr = pwdata; evt = 1; end
            else if (tk) begin nc = m_cnt + 1; evt = 1; end
            if (wr && paddr == 12'h004) begin nm = pwdata; evt = 1; end
            if (wr && paddr == 12'h010) m_mask = pwdata[0];
            if (evt && nc == nm) m_raw = 1;
            else if (wr && paddr == 12'h01C) m_raw = 0;
            m_cnt = nc; m_mr = nm;
        end
    end

    function automatic bit [31:0] model_read(input bit [11:0] a);
        if (a >= 12'hFE0 && a[1:0] == 0) return {24'd0, ids[(a - 12'hFE0) >> 2]};
        case (a)
            12'h000: return m_cnt;
            12'h004: return m_mr;
            12'h008: return m_lr;
            12'h00C: return 32'd1;
            12'h010: return {31'd0, m_mask};
            12'h014: return {31'd0, m_raw};
            12'h018: return {31'd0, m_raw & m_mask};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input bit [31:0] got, input bit [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
        end
    endtask

    // every-clock pin comparison (R6)
    always @(negedge clk) if (rst_n && !done) check("R6 irq", {31'd0, irq_o}, {31'd0, m_raw & m_mask});

    task automatic bus_wr(input bit [11:0] a, input bit [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_rd(input bit [11:0] a, input string tag, output bit [31:0] got);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1;
        #1 got = prdata;
        check(tag, got, model_read(a));
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic sync_to(input int v);
        do @(negedge clk); while (pcnt != v);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        bit [31:0] v, v2;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        foreach (ids[i]) begin end
        bus_rd(12'h000, "R1 count", v);  check("R1 count small", {31'd0, v > 1}, 0);
        bus_rd(12'h004, "R1 match", v);  check("R1 match zero", v, 0);
        bus_rd(12'h008, "R1 load", v);   check("R1 load zero", v, 0);
        bus_rd(12'h010, "R1 mask", v);   check("R1 mask zero", v, 0);
        bus_rd(12'h014, "R1 raw", v);    check("R1 raw zero", v, 0);
        check("R1 irq", {31'd0, irq_o}, 0);

        // R2 counting
        bus_rd(12'h000, "R2 count a", v);
        idle(3 * DIV);
        bus_rd(12'h000, "R2 count b", v2);
        check("R2 delta", {31'd0, (v2 - v == 3) || (v2 - v == 4)}, 1);

        // R3 load and readback
        bus_wr(12'h008, 32'h0000_1000);
        bus_rd(12'h008, "R3 load readback", v); check("R3 load value", v, 32'h1000);
        bus_rd(12'h000, "R3 count after load", v);

        // R6 mask keeps bit 0 only
        bus_wr(12'h010, 32'hFFFF_FFFE);
        bus_rd(12'h010, "R6 mask even", v); check("R6 mask even value", v, 0);
        bus_wr(12'h010, 32'hFFFF_FFFF);
        bus_rd(12'h010, "R6 mask odd", v);  check("R6 mask odd value", v, 1);

        // R4 future match via tick
        sync_to(0);
        bus_wr(12'h008, 32'h0000_2000);
        bus_wr(12'h004, 32'h0000_2002);
        idle(3 * DIV);
        check("R4 irq after match", {31'd0, irq_o}, 1);
        bus_rd(12'h014, "R4 raw", v); check("R4 raw value", v, 1);

        // R7 clear with zero data
        bus_wr(12'h01C, 32'h0);
        bus_rd(12'h014, "R7 raw cleared", v); check("R7 raw cleared value", v, 0);

        // R5 load onto match, then match onto count
        sync_to(0);
        bus_wr(12'h004, 32'h0000_0077);
        bus_wr(12'h008, 32'h0000_0077);
        bus_rd(12'h014, "R5 raw by load", v); check("R5 raw by load value", v, 1);
        bus_wr(12'h01C, 32'hFFFF_FFFF);
        sync_to(0);
        bus_wr(12'h008, 32'h0000_0200);
        bus_wr(12'h004, 32'h0000_0200);
        bus_rd(12'h014, "R5 raw by match", v); check("R5 raw by match value", v, 1);
        bus_wr(12'h01C, 32'h0);

        // R4 wrap: match below count
        sync_to(0);
        bus_wr(12'h004, 32'h0000_0000);
        bus_wr(12'h008, 32'hFFFF_FFFE);
        idle(DIV);
        check("R4 no early fire", {31'd0, irq_o}, 0);
        idle(2 * DIV);
        check("R4 fire after wrap", {31'd0, irq_o}, 1);
        bus_wr(12'h01C, 32'h0);

        // R7 clear in the same cycle as a hit
        sync_to(0);
        bus_wr(12'h004, 32'h0000_0301);
        bus_wr(12'h008, 32'h0000_0300);
        sync_to(DIV - 3);
        bus_wr(12'h01C, 32'h1);
        bus_rd(12'h014, "R7 hit beats clear", v); check("R7 hit beats clear value", v, 1);
        bus_wr(12'h01C, 32'h0);

        // R3 load in a tick cycle
        sync_to(DIV - 3);
        bus_wr(12'h008, 32'h0000_0500);
        bus_rd(12'h000, "R3 load beats tick", v); check("R3 load beats tick value", v, 32'h500);

        // R8 control constant
        bus_wr(12'h00C, 32'h0);
        bus_rd(12'h00C, "R8 ctrl", v); check("R8 ctrl value", v, 1);

        // R9 ignored writes and zero reads
        bus_wr(12'h004, 32'h0000_0500);
        bus_wr(12'h008, 32'h0000_0500);
        bus_wr(12'h014, 32'h0);
        bus_wr(12'h018, 32'h0);
        bus_rd(12'h014, "R9 raw kept", v); check("R9 raw kept value", v, 1);
        sync_to(0);
        bus_wr(12'h008, 32'h0000_0600);
        bus_wr(12'h000, 32'hDEAD_BEEF);
        bus_rd(12'h000, "R9 count kept", v); check("R9 count kept value", v, 32'h600);
        bus_rd(12'h01C, "R9 clear reads 0", v); check("R9 clear value", v, 0);
        bus_rd(12'h020, "R9 unmapped", v); check("R9 unmapped value", v, 0);
        bus_rd(12'h005, "R9 unaligned", v); check("R9 unaligned value", v, 0);

        // R6 mask off hides irq but keeps raw
        bus_wr(12'h010, 32'h0);
        bus_rd(12'h018, "R6 masked status", v); check("R6 masked status value", v, 0);
        bus_rd(12'h014, "R6 raw under mask", v); check("R6 raw under mask value", v, 1);
        check("R6 irq masked", {31'd0, irq_o}, 0);

        // R10 identification bytes
        for (int i = 0; i < 8; i++) begin
            bus_rd(12'hFE0 + 12'(4 * i), "R10 id", v);
            check("R10 id value", v, {24'd0, ids[i]});
        end

        // R11 no read data during writes
        @(negedge clk); psel = 1; pwrite = 1; paddr = 12'h00C; penable = 0;
        #1 check("R11 prdata zero on write", prdata, 0);
        @(negedge clk); psel = 0; pwrite = 0;

        idle(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule